// File: doc/BRIEF.md
# Audio FIFO Status and Interrupt Unit

This unit connects a 32-bit register bus to a serial audio link. It holds a 16-entry transmit queue and a 16-entry receive queue. One data address reaches both: a bus write places a word in the transmit queue, and a bus read takes the oldest word out of the receive queue. The serializer, which lies outside this unit, takes transmit words with a pop strobe and delivers received words with a push strobe.

From the two queue levels the unit derives service requests against programmable thresholds. It also keeps sticky flags for receive overrun and transmit underrun. A status word reports these together with the link state. A mask register selects which sources drive the single interrupt line, and a write-one-to-clear register resets the sticky flags. The control register holds the two thresholds, the link enable and a soft reset. The soft reset empties both queues and zeroes the other state for as long as it is set.

Registers sit at word indices on a 3-bit address: control 0, status 1, mask 2, clear 3, data 4. Any other index reads zero. Bus reads are registered, so read data is valid in the cycle after the read strobe.

Top module: `aud_fifo_irq_unit`

## Requirements
- R1: After reset the control and mask registers read 0, the status register reads 0x89 (controller off, transmit service, transmit not full) and `irq` is 0.
- R2: Words written to data index 4 leave on `link_tx_data` in write order. `link_tx_data` shows the oldest transmit entry, or zero when the queue is empty, and a `link_pop` strobe removes that entry.
- R3: A read of data index 4 returns the received words in arrival order. A read from an empty receive queue returns zero and leaves the queue unchanged. Status bit 1 is 1 while the receive queue holds any entry.
- R4: Status bit 0 is 1 unless the transmit queue holds 16 entries. A write to a full transmit queue is dropped.
- R5: Status bit 4 (receive service) is 1 when the receive occupancy is nonzero and at least control bits 15:12.
- R6: Status bit 3 (transmit service) is 1 when the transmit occupancy is at most control bits 11:8.
- R7: A `link_push` into a full receive queue drops the word and sets status bit 6. The bit stays set until it is cleared.
- R8: A `link_pop` from an empty transmit queue sets status bit 5. The bit stays set until it is cleared.
- R9: Writing 1 to clear-register bit 6 or bit 5 clears the matching sticky flag. Zero bits in that write have no effect.
- R10: `irq` is the OR, over status bits 6, 5, 4 and 3, of each bit ANDed with the same bit of the mask register.
- R11: While control bit 3 is 1, both queues are empty and the flags, the mask and every other control field read 0.
- R12: Status bit 2 equals `link_busy`. Status bit 7 is 1 when control bit 0 (link enable) is 0 and `link_busy` is 0.
- R13: The control register reads back the receive threshold at bits 15:12, the transmit threshold at bits 11:8, soft reset at bit 3 and enable at bit 0. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| link_push | input | 1 | Serializer delivers a received word |
| link_rx_data | input | 32 | Received word |
| link_pop | input | 1 | Serializer takes the oldest transmit word |
| link_tx_data | output | 32 | Oldest transmit word, zero when empty |
| link_busy | input | 1 | Serializer is inside a frame |
| link_en | output | 1 | Link enable from control bit 0 |
| irq | output | 1 | Masked interrupt request |

## Verification
A register write, push or pop takes effect at the clock edge where it is sampled. The status word, `irq` and `link_tx_data` reflect it from the following half cycle onward, because they are derived from registers without further delay. A bus read captures the state present at its own edge, so `bus_rdata` is valid one cycle after `bus_rd`. The bench drives every strobe for one cycle from a falling edge and samples at the next falling edge, so each read shows every earlier stimulus and none of the later ones. The threshold checks sweep all 16 values of each threshold against every occupancy from 0 to 16. The interrupt check sweeps all 16 mask patterns against a known set of sources.

// File: rtl/aud_pkg.sv
package aud_pkg;

    // register word indices
    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_STAT = 3'd1;
    localparam logic [2:0] A_MASK = 3'd2;
    localparam logic [2:0] A_CLR  = 3'd3;
    localparam logic [2:0] A_DATA = 3'd4;

    // control bit positions
    localparam int C_RXTH_LO = 12;
    localparam int C_TXTH_LO = 8;
    localparam int C_SRST    = 3;
    localparam int C_EN      = 0;
    localparam int TH_W      = 4;

    // status / mask / clear bit positions
    localparam int S_OFF  = 7;
    localparam int S_OVR  = 6;
    localparam int S_UDR  = 5;
    localparam int S_RXSV = 4;
    localparam int S_TXSV = 3;
    localparam int S_BUSY = 2;
    localparam int S_RXNE = 1;
    localparam int S_TXNF = 0;

    typedef struct packed {
        logic [TH_W-1:0] rx_th;
        logic [TH_W-1:0] tx_th;
        logic            srst;
        logic            en;
    } ctrl_t;

endpackage

// File: rtl/aud_fifo.sv
module aud_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic                     wr_en,
    input  logic [DW-1:0]            wr_data,
    input  logic                     rd_en,
    output logic [DW-1:0]            head,
    output logic [$clog2(DEPTH):0]   count,
    output logic                     full,
    output logic                     empty,
    output logic                     wr_drop,
    output logic                     rd_drop
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = PW + 1;
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [PW-1:0] LAST     = PW'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [PW-1:0]            wp;
        logic [PW-1:0]            rp;
        logic [CW-1:0]            cnt;
    } fifo_st_t;

    fifo_st_t s_d, s_q;
    logic     do_wr, do_rd;

    assign full    = (s_q.cnt == FULL_CNT);
    assign empty   = (s_q.cnt == '0);
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;
    assign wr_drop = wr_en && full;
    assign rd_drop = rd_en && empty;
    assign count   = s_q.cnt;
    assign head    = empty ? '0 : s_q.mem[s_q.rp];

    always_comb begin
        s_d = s_q;
        if (flush) begin
            s_d.wp  = '0;
            s_d.rp  = '0;
            s_d.cnt = '0;
        end else begin
            if (do_wr) begin
                s_d.mem[s_q.wp] = wr_data;
                s_d.wp = (s_q.wp == LAST) ? '0 : s_q.wp + 1'b1;
            end
            if (do_rd) begin
                s_d.rp = (s_q.rp == LAST) ? '0 : s_q.rp + 1'b1;
            end
            case ({do_wr, do_rd})
                2'b10:   s_d.cnt = s_q.cnt + 1'b1;
                2'b01:   s_d.cnt = s_q.cnt - 1'b1;
                default: s_d.cnt = s_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= FULL_CNT);

    // R4
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en && !flush) |=> full);

    // R3
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en && !wr_en) |=> empty);

endmodule

// File: rtl/aud_status.sv
module aud_status #(
    parameter int DEPTH = 16
) (
    input  aud_pkg::ctrl_t           ctrl,
    input  logic [$clog2(DEPTH):0]   rx_cnt,
    input  logic [$clog2(DEPTH):0]   tx_cnt,
    input  logic                     ovr,
    input  logic                     udr,
    input  logic                     busy,
    input  logic [3:0]               mask,
    output logic [7:0]               stat,
    output logic                     irq
);
    import aud_pkg::*;
    localparam int CW = $clog2(DEPTH) + 1;
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [CW-1:0] rx_th_w, tx_th_w;

    always_comb begin
        rx_th_w      = CW'(ctrl.rx_th);
        tx_th_w      = CW'(ctrl.tx_th);
        stat         = '0;
        stat[S_OFF]  = !ctrl.en && !busy;
        stat[S_OVR]  = ovr;
        stat[S_UDR]  = udr;
        stat[S_RXSV] = (rx_cnt != '0) && (rx_cnt >= rx_th_w);
        stat[S_TXSV] = (tx_cnt <= tx_th_w);
        stat[S_BUSY] = busy;
        stat[S_RXNE] = (rx_cnt != '0);
        stat[S_TXNF] = (tx_cnt != FULL_CNT);
        irq          = |(stat[S_OVR:S_TXSV] & mask);
    end

endmodule

// File: rtl/aud_fifo_irq_unit.sv
module aud_fifo_irq_unit #(
    parameter int DW    = 32,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [2:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          link_push,
    input  logic [DW-1:0] link_rx_data,
    input  logic          link_pop,
    output logic [DW-1:0] link_tx_data,
    input  logic          link_busy,
    output logic          link_en,
    output logic          irq
);
    import aud_pkg::*;
    localparam int CW = $clog2(DEPTH) + 1;

    typedef struct packed {
        ctrl_t         ctrl;
        logic [3:0]    mask;
        logic          ovr;
        logic          udr;
        logic [DW-1:0] rdata;
    } regs_t;

    regs_t r_d, r_q;

    logic          srst;
    logic          wr_ctrl, wr_mask, wr_clr, wr_data, rd_data;
    logic [DW-1:0] rx_head;
    logic [CW-1:0] rx_cnt, tx_cnt;
    logic          rx_full, rx_empty, rx_wdrop, rx_rdrop;
    logic          tx_full, tx_empty, tx_wdrop, tx_rdrop;
    logic [7:0]    stat;

    assign srst    = r_q.ctrl.srst;
    assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
    assign wr_mask = bus_wr && (bus_addr == A_MASK);
    assign wr_clr  = bus_wr && (bus_addr == A_CLR);
    assign wr_data = bus_wr && (bus_addr == A_DATA);
    assign rd_data = bus_rd && (bus_addr == A_DATA);

    aud_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (srst),
        .wr_en   (wr_data),
        .wr_data (bus_wdata),
        .rd_en   (link_pop),
        .head    (link_tx_data),
        .count   (tx_cnt),
        .full    (tx_full),
        .empty   (tx_empty),
        .wr_drop (tx_wdrop),
        .rd_drop (tx_rdrop)
    );

    aud_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (srst),
        .wr_en   (link_push),
        .wr_data (link_rx_data),
        .rd_en   (rd_data),
        .head    (rx_head),
        .count   (rx_cnt),
        .full    (rx_full),
        .empty   (rx_empty),
        .wr_drop (rx_wdrop),
        .rd_drop (rx_rdrop)
    );

    aud_status #(.DEPTH(DEPTH)) u_stat (
        .ctrl   (r_q.ctrl),
        .rx_cnt (rx_cnt),
        .tx_cnt (tx_cnt),
        .ovr    (r_q.ovr),
        .udr    (r_q.udr),
        .busy   (link_busy),
        .mask   (r_q.mask),
        .stat   (stat),
        .irq    (irq)
    );

    always_comb begin
        r_d = r_q;

        // control register; a soft reset write keeps only the reset bit
        if (wr_ctrl) begin
            if (bus_wdata[C_SRST]) begin
                r_d.ctrl      = '0;
                r_d.ctrl.srst = 1'b1;
            end else begin
                r_d.ctrl.rx_th = bus_wdata[C_RXTH_LO +: TH_W];
                r_d.ctrl.tx_th = bus_wdata[C_TXTH_LO +: TH_W];
                r_d.ctrl.srst  = 1'b0;
                r_d.ctrl.en    = bus_wdata[C_EN];
            end
        end

        if (srst) begin
            r_d.mask = '0;
            r_d.ovr  = 1'b0;
            r_d.udr  = 1'b0;
        end else begin
            if (wr_mask) r_d.mask = bus_wdata[S_OVR:S_TXSV];
            // set wins over a same-cycle clear
            r_d.ovr = rx_wdrop || (r_q.ovr && !(wr_clr && bus_wdata[S_OVR]));
            r_d.udr = tx_rdrop || (r_q.udr && !(wr_clr && bus_wdata[S_UDR]));
        end

        if (bus_rd) begin
            case (bus_addr)
                A_CTRL:  r_d.rdata = DW'({r_q.ctrl.rx_th, r_q.ctrl.tx_th, 4'b0,
                                          r_q.ctrl.srst, 2'b0, r_q.ctrl.en});
                A_STAT:  r_d.rdata = DW'(stat);
                A_MASK:  r_d.rdata = DW'({r_q.mask, 3'b0});
                A_DATA:  r_d.rdata = rx_head;
                default: r_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign bus_rdata = r_q.rdata;
    assign link_en   = r_q.ctrl.en;

    // R7
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ovr && !srst && !(wr_clr && bus_wdata[S_OVR])) |=> stat[S_OVR]);

    // R7
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_push && rx_full && !srst) |=> stat[S_OVR]);

    // R8
    udr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_pop && tx_empty && !srst) |=> stat[S_UDR]);

    // R10
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|stat[S_OVR:S_TXSV]));

    // R11
    srst_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (rx_empty && tx_empty));

    // R4
    tx_full_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_full |-> !stat[S_TXNF]);

endmodule

// File: tb/aud_fifo_irq_unit_tb.sv
`timescale 1ns/1ps
module aud_fifo_irq_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        link_push = 1'b0, link_pop = 1'b0, link_busy = 1'b0;
    logic [31:0] link_rx_data = '0;
    logic [31:0] link_tx_data;
    logic        link_en, irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    aud_fifo_irq_unit u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .link_push(link_push), .link_rx_data(link_rx_data), .link_pop(link_pop),
        .link_tx_data(link_tx_data), .link_busy(link_busy), .link_en(link_en),
        .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic push(input logic [31:0] d);
        @(negedge clk);
        link_push = 1'b1; link_rx_data = d;
        @(negedge clk);
        link_push = 1'b0;
    endtask

    task automatic pop(output logic [31:0] v);
        @(negedge clk);
        v = link_tx_data;
        link_pop = 1'b1;
        @(negedge clk);
        link_pop = 1'b0;
    endtask

    task automatic soft_reset(input logic [31:0] ctrl_after);
        wr(3'd0, 32'h8);
        wr(3'd0, ctrl_after);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(3'd1, v); chk("R1 status", v, 32'h89);
        rd(3'd0, v); chk("R1 ctrl", v, 32'h0);
        rd(3'd2, v); chk("R1 mask", v, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // R13 control readback: bits 31:16 and 2 are not stored
        wr(3'd0, 32'hFFFF_E105);
        rd(3'd0, v); chk("R13 ctrl readback", v, 32'h0000_E101);
        chk("R13 link_en", {31'b0, link_en}, 32'h1);

        // R12 busy / controller off, all four combinations
        for (int e = 0; e < 2; e++) begin
            for (int b = 0; b < 2; b++) begin
                wr(3'd0, 32'(e));
                link_busy = b[0];
                rd(3'd1, v);
                chk("R12 off bit", {31'b0, v[7]}, {31'b0, (e == 0) && (b == 0)});
                chk("R12 busy bit", {31'b0, v[2]}, 32'(b));
            end
        end
        link_busy = 1'b0;

        // R2 / R4 transmit order and full drop
        soft_reset(32'h0);
        for (int i = 0; i < 17; i++) wr(3'd4, 32'hA500_0000 + 32'(i));
        rd(3'd1, v); chk("R4 tx not full clear", {31'b0, v[0]}, 32'h0);
        for (int i = 0; i < 16; i++) begin
            pop(v); chk("R2 tx order", v, 32'hA500_0000 + 32'(i));
        end
        rd(3'd1, v); chk("R8 no underrun yet", {31'b0, v[5]}, 32'h0);
        chk("R4 dropped word absent", link_tx_data, 32'h0);
        pop(v);
        rd(3'd1, v); chk("R8 underrun set", {31'b0, v[5]}, 32'h1);
        rd(3'd1, v); chk("R8 underrun sticky", {31'b0, v[5]}, 32'h1);

        // R3 receive order and empty read
        soft_reset(32'h0);
        for (int i = 0; i < 5; i++) push(32'h5A00_0000 + 32'(i));
        rd(3'd1, v); chk("R3 rx not empty", {31'b0, v[1]}, 32'h1);
        for (int i = 0; i < 5; i++) begin
            rd(3'd4, v); chk("R3 rx order", v, 32'h5A00_0000 + 32'(i));
        end
        rd(3'd4, v); chk("R3 empty read zero", v, 32'h0);
        rd(3'd1, v); chk("R3 rx empty", {31'b0, v[1]}, 32'h0);
        push(32'h1234_5678);
        rd(3'd4, v); chk("R3 queue intact after empty read", v, 32'h1234_5678);

        // R7 / R9 overrun and clearing
        soft_reset(32'h0);
        for (int i = 0; i < 17; i++) push(32'h3C00_0000 + 32'(i));
        rd(3'd1, v); chk("R7 overrun set", {31'b0, v[6]}, 32'h1);
        pop(v);
        wr(3'd3, 32'h0);
        rd(3'd1, v); chk("R9 zero write keeps overrun", {31'b0, v[6]}, 32'h1);
        wr(3'd3, 32'h20);
        rd(3'd1, v);
        chk("R9 bit5 clears underrun", {31'b0, v[5]}, 32'h0);
        chk("R9 bit5 keeps overrun", {31'b0, v[6]}, 32'h1);
        for (int i = 0; i < 16; i++) begin
            rd(3'd4, v); chk("R7 kept words", v, 32'h3C00_0000 + 32'(i));
        end
        rd(3'd4, v); chk("R7 dropped word absent", v, 32'h0);
        rd(3'd1, v); chk("R7 overrun sticky", {31'b0, v[6]}, 32'h1);
        wr(3'd3, 32'h40);
        rd(3'd1, v); chk("R9 bit6 clears overrun", {31'b0, v[6]}, 32'h0);

        // R5 receive threshold sweep
        for (int th = 0; th < 16; th++) begin
            soft_reset(32'(th) << 12);
            for (int n = 0; n <= 16; n++) begin
                rd(3'd1, v);
                chk("R5 rx service", {31'b0, v[4]}, {31'b0, (n != 0) && (n >= th)});
                if (n < 16) push(32'(n));
            end
        end

        // R6 transmit threshold sweep
        for (int th = 0; th < 16; th++) begin
            soft_reset(32'(th) << 8);
            for (int n = 0; n <= 16; n++) begin
                rd(3'd1, v);
                chk("R6 tx service", {31'b0, v[3]}, {31'b0, n <= th});
                chk("R4 tx not full", {31'b0, v[0]}, {31'b0, n != 16});
                if (n < 16) wr(3'd4, 32'(n));
            end
        end

        // R10 interrupt mask sweep: sources ovr=0 udr=1 rxsv=1 txsv=1
        soft_reset(32'h0000_2000);
        push(32'h1); push(32'h2);
        pop(v);
        for (int m = 0; m < 16; m++) begin
            wr(3'd2, 32'(m) << 3);
            chk("R10 irq", {31'b0, irq}, {31'b0, |(m[3:0] & 4'b0111)});
        end
        rd(3'd2, v); chk("R10 mask readback", v, 32'h78);

        // R11 soft reset clears everything while set
        for (int i = 0; i < 3; i++) wr(3'd4, 32'hF0 + 32'(i));
        wr(3'd0, 32'h0000_E109);
        rd(3'd1, v); chk("R11 status in reset", v, 32'h89);
        rd(3'd2, v); chk("R11 mask in reset", v, 32'h0);
        rd(3'd0, v); chk("R11 ctrl in reset", v, 32'h8);
        rd(3'd4, v); chk("R11 rx data in reset", v, 32'h0);
        chk("R11 tx data in reset", link_tx_data, 32'h0);
        chk("R11 irq in reset", {31'b0, irq}, 32'h0);
        wr(3'd0, 32'h0);
        rd(3'd1, v); chk("R11 status after release", v, 32'h89);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule